// File: doc/BRIEF.md
# Half-Duplex Transmit Retry Controller

This block sits beside a half-duplex Ethernet transmit engine. It decides what happens after each transmit attempt. When an attempt ends, the engine presents a one-cycle outcome report that flags a collision, whether that collision was late, a FIFO underflow and a FIFO overflow. Using per-class retry enables, the controller answers with exactly one action: a retry pulse, a drop pulse, or nothing when the attempt succeeded.

The controller counts consecutive collisions. For a collision retry it draws a random wait from a free-running LFSR, in whole slot times, and the window for that wait grows by powers of two up to a cap. The busy output stays high for the wait, and the engine must not start a new attempt while it is high. Late collisions and the excessive-collision case share one retry enable. Underflow has its own enable. Overflow is never retried. Four sticky status flags record the error classes until software pulses a clear.

Top module: `hd_retry_ctrl`

## Requirements
- R1: An accepted report with a collision that is neither late nor the sixteenth in a row gives a retry pulse when `en_coll_retry` is 1, and a drop pulse otherwise.
- R2: After a collision retry, `backoff_busy` stays high for exactly k*SLOT_CYCLES cycles, starting in the cycle of the retry pulse. k is an integer in [0, 2^min(n,10) − 1], and n is the consecutive-collision count including this attempt. When k is 0, busy does not rise.
- R3: A collision reported with `ev_late`=1 sets `sts_late`. The frame is retried if `en_fatal_retry` is 1 and dropped otherwise.
- R4: The sixteenth consecutive collision sets `sts_excess` and is retried only if `en_fatal_retry` is 1. The collision count then restarts from zero.
- R5: An underflow without collision or overflow sets `sts_ufl`. It is retried with no backoff if `en_ufl_retry` is 1 and dropped otherwise. A collision in the same report takes precedence over the underflow.
- R6: Overflow sets `sts_ovf` and always drops the frame, whatever else the report flags and whatever the enables are.
- R7: The collision count returns to zero on a successful attempt, on any drop, and on any outcome without a collision.
- R8: Status flags are sticky until `clr_status` is 1. A new error in the same cycle as the clear wins, and the flag stays set.
- R9: Retry and drop are one-cycle pulses that never coincide. Each appears in the cycle after the accepted report.
- R10: `backoff_busy` rises only together with a retry pulse. A report given while busy is high is ignored: no pulse, no status change, and no change to the count.
- R11: After reset all outputs are 0 and the collision count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | One-cycle attempt-outcome report |
| ev_coll | input | 1 | Attempt ended in a collision |
| ev_late | input | 1 | Collision came after the minimum frame length |
| ev_ufl | input | 1 | Transmit FIFO underflow during the attempt |
| ev_ovf | input | 1 | Transmit FIFO overflow |
| en_coll_retry | input | 1 | Retry ordinary collisions |
| en_fatal_retry | input | 1 | Retry late and excessive collisions |
| en_ufl_retry | input | 1 | Retry underflows |
| clr_status | input | 1 | Clear sticky status flags |
| retry_pulse | output | 1 | Retry the frame |
| drop_pulse | output | 1 | Drop the frame |
| backoff_busy | output | 1 | Backoff in progress; hold off transmit start |
| sts_excess | output | 1 | Sticky excessive-collision flag |
| sts_late | output | 1 | Sticky late-collision flag |
| sts_ufl | output | 1 | Sticky underflow flag |
| sts_ovf | output | 1 | Sticky overflow flag |

## Verification
On every cycle, the assertions check the following: pulse exclusivity and pulse width, that busy rises only with a retry, stickiness of the flags, that overflow always drops, that an underflow retry has no wait, and that reports arriving during busy are ignored. Some properties need the outcome history and only the bench's scenarios can show them. These are the sixteenth-collision boundary, the count restarting after success or a drop, and the busy length being a whole number of slots inside the window for the current attempt number. A behavioural model in the bench checks all of these.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

    typedef struct packed {
        logic coll;
        logic late;
        logic ufl;
        logic ovf;
    } outcome_t;

    typedef struct packed {
        logic excess;
        logic late;
        logic ufl;
        logic ovf;
    } status_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_RETRY_WAIT,
        ACT_RETRY_NOW,
        ACT_DROP
    } action_e;

    function automatic logic [15:0] lfsr_step(input logic [15:0] s, input logic [15:0] taps);
        return s[0] ? ((s >> 1) ^ taps) : (s >> 1);
    endfunction

    function automatic int unsigned clip_exp(input int unsigned n, input int unsigned cap);
        return (n < cap) ? n : cap;
    endfunction

endpackage

// File: rtl/hdr_lfsr.sv
module hdr_lfsr #(
    parameter int          OUT_W = 10,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] rnd
);
    import hdr_pkg::*;

    logic [15:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= lfsr_step(state_q, TAPS);
    end

    assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/hdr_backoff_timer.sv
module hdr_backoff_timer #(
    parameter int SLOT_CYCLES = 64,
    parameter int K_W         = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [K_W-1:0] slots,
    output logic           busy
);
    localparam int SW = $clog2(SLOT_CYCLES + 1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_CYCLES - 1);

    logic [K_W-1:0] left_q;
    logic [SW-1:0]  cyc_q;
    logic           busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            left_q <= '0;
            cyc_q  <= '0;
        end else if (load) begin
            busy_q <= (slots != '0);
            left_q <= slots;
            cyc_q  <= SLOT_LAST;
        end else if (busy_q) begin
            if (cyc_q == '0) begin
                if (left_q == K_W'(1)) begin
                    busy_q <= 1'b0;
                end else begin
                    left_q <= left_q - 1'b1;
                    cyc_q  <= SLOT_LAST;
                end
            end else begin
                cyc_q <= cyc_q - 1'b1;
            end
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/hdr_decide.sv
module hdr_decide #(
    parameter int MAX_ATTEMPTS = 16,
    parameter int CAP_EXP      = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  hdr_pkg::outcome_t  res,
    input  logic               en_coll,
    input  logic               en_fatal,
    input  logic               en_ufl,
    input  logic               clr,
    input  logic [CAP_EXP-1:0] rnd,
    output logic               retry_q,
    output logic               drop_q,
    output hdr_pkg::status_t   sts_q,
    output logic               bo_load,
    output logic [CAP_EXP-1:0] bo_slots
);
    import hdr_pkg::*;

    localparam int CW = $clog2(MAX_ATTEMPTS + 1);

    logic [CW-1:0]      cnt_q, cnt_inc, cnt_d;
    logic               excess;
    action_e            act;
    logic [CAP_EXP-1:0] mask;
    status_t            sts_set;
    int unsigned        e;

    assign cnt_inc = cnt_q + 1'b1;
    assign excess  = res.coll && (cnt_inc == CW'(MAX_ATTEMPTS));

    always_comb begin
        if (res.ovf)
            act = ACT_DROP;
        else if (res.coll)
            act = ((res.late || excess) ? en_fatal : en_coll) ? ACT_RETRY_WAIT : ACT_DROP;
        else if (res.ufl)
            act = en_ufl ? ACT_RETRY_NOW : ACT_DROP;
        else
            act = ACT_NONE;
    end

    always_comb begin
        e = clip_exp(int'(cnt_inc), CAP_EXP);
        for (int i = 0; i < CAP_EXP; i++) mask[i] = (i < e);
    end

    always_comb begin
        if (!fire)
            cnt_d = cnt_q;
        else if (act == ACT_RETRY_WAIT && !excess)
            cnt_d = cnt_inc;
        else
            cnt_d = '0;
    end

    always_comb begin
        sts_set.excess = fire && excess;
        sts_set.late   = fire && res.coll && res.late;
        sts_set.ufl    = fire && res.ufl;
        sts_set.ovf    = fire && res.ovf;
    end

    assign bo_load  = fire && (act == ACT_RETRY_WAIT);
    assign bo_slots = rnd & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            retry_q <= 1'b0;
            drop_q  <= 1'b0;
            sts_q   <= '0;
        end else begin
            cnt_q   <= cnt_d;
            retry_q <= fire && (act == ACT_RETRY_WAIT || act == ACT_RETRY_NOW);
            drop_q  <= fire && (act == ACT_DROP);
            sts_q   <= (clr ? status_t'('0) : sts_q) | sts_set;
        end
    end
endmodule

// File: rtl/hd_retry_ctrl.sv
module hd_retry_ctrl #(
    parameter int SLOT_CYCLES  = 64,
    parameter int MAX_ATTEMPTS = 16,
    parameter int BACKOFF_CAP  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic ev_valid,
    input  logic ev_coll,
    input  logic ev_late,
    input  logic ev_ufl,
    input  logic ev_ovf,
    input  logic en_coll_retry,
    input  logic en_fatal_retry,
    input  logic en_ufl_retry,
    input  logic clr_status,
    output logic retry_pulse,
    output logic drop_pulse,
    output logic backoff_busy,
    output logic sts_excess,
    output logic sts_late,
    output logic sts_ufl,
    output logic sts_ovf
);
    import hdr_pkg::*;

    localparam int K_W = BACKOFF_CAP;

    outcome_t       res;
    status_t        sts;
    logic           fire, bo_load, busy;
    logic [K_W-1:0] rnd, bo_slots;

    assign res  = '{coll: ev_coll, late: ev_late, ufl: ev_ufl, ovf: ev_ovf};
    assign fire = ev_valid && !busy;

    hdr_lfsr #(.OUT_W(K_W)) u_lfsr (
        .clk(clk), .rst(rst), .rnd(rnd)
    );

    hdr_decide #(.MAX_ATTEMPTS(MAX_ATTEMPTS), .CAP_EXP(K_W)) u_decide (
        .clk(clk), .rst(rst), .fire(fire), .res(res),
        .en_coll(en_coll_retry), .en_fatal(en_fatal_retry), .en_ufl(en_ufl_retry),
        .clr(clr_status), .rnd(rnd),
        .retry_q(retry_pulse), .drop_q(drop_pulse), .sts_q(sts),
        .bo_load(bo_load), .bo_slots(bo_slots)
    );

    hdr_backoff_timer #(.SLOT_CYCLES(SLOT_CYCLES), .K_W(K_W)) u_timer (
        .clk(clk), .rst(rst), .load(bo_load), .slots(bo_slots), .busy(busy)
    );

    assign backoff_busy = busy;
    assign sts_excess   = sts.excess;
    assign sts_late     = sts.late;
    assign sts_ufl      = sts.ufl;
    assign sts_ovf      = sts.ovf;
endmodule

// File: rtl/hd_retry_ctrl_chk.sv
module hd_retry_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ev_valid,
    input logic ev_coll,
    input logic ev_late,
    input logic ev_ufl,
    input logic ev_ovf,
    input logic clr_status,
    input logic retry_pulse,
    input logic drop_pulse,
    input logic backoff_busy,
    input logic sts_excess,
    input logic sts_late,
    input logic sts_ufl,
    input logic sts_ovf
);
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(retry_pulse && drop_pulse));

    p_retry_width_r9: assert property (@(posedge clk) disable iff (rst)
        retry_pulse |=> !retry_pulse);

    p_drop_width_r9: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |=> !drop_pulse);

    p_busy_src_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(backoff_busy) |-> retry_pulse);

    p_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && backoff_busy) |=> (!retry_pulse && !drop_pulse));

    p_ovf_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !backoff_busy && ev_ovf) |=> (drop_pulse && sts_ovf));

    p_late_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !backoff_busy && ev_coll && ev_late) |=> sts_late);

    p_ufl_nowait_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !backoff_busy && ev_ufl && !ev_coll && !ev_ovf) |=> (sts_ufl && !backoff_busy));

    p_sticky_exc_r8: assert property (@(posedge clk) disable iff (rst)
        (sts_excess && !clr_status) |=> sts_excess);

    p_sticky_late_r8: assert property (@(posedge clk) disable iff (rst)
        (sts_late && !clr_status) |=> sts_late);

    p_sticky_ufl_r8: assert property (@(posedge clk) disable iff (rst)
        (sts_ufl && !clr_status) |=> sts_ufl);

    p_sticky_ovf_r8: assert property (@(posedge clk) disable iff (rst)
        (sts_ovf && !clr_status) |=> sts_ovf);
endmodule

bind hd_retry_ctrl hd_retry_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_coll(ev_coll), .ev_late(ev_late),
    .ev_ufl(ev_ufl), .ev_ovf(ev_ovf), .clr_status(clr_status),
    .retry_pulse(retry_pulse), .drop_pulse(drop_pulse), .backoff_busy(backoff_busy),
    .sts_excess(sts_excess), .sts_late(sts_late), .sts_ufl(sts_ufl), .sts_ovf(sts_ovf)
);

// File: tb/hd_retry_ctrl_tb_top.sv
`timescale 1ns/100ps
module hd_retry_ctrl_tb_top;
    localparam int SLOT = 4;
    localparam int MAXA = 16;
    localparam int CAP  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_valid = 0, ev_coll = 0, ev_late = 0, ev_ufl = 0, ev_ovf = 0;
    logic en_coll_retry = 0, en_fatal_retry = 0, en_ufl_retry = 0, clr_status = 0;
    logic retry_pulse, drop_pulse, backoff_busy;
    logic sts_excess, sts_late, sts_ufl, sts_ovf;

    always #2.5 clk = ~clk;

    hd_retry_ctrl #(.SLOT_CYCLES(SLOT), .MAX_ATTEMPTS(MAXA), .BACKOFF_CAP(CAP)) dut_i (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_coll(ev_coll), .ev_late(ev_late),
        .ev_ufl(ev_ufl), .ev_ovf(ev_ovf), .en_coll_retry(en_coll_retry),
        .en_fatal_retry(en_fatal_retry), .en_ufl_retry(en_ufl_retry), .clr_status(clr_status),
        .retry_pulse(retry_pulse), .drop_pulse(drop_pulse), .backoff_busy(backoff_busy),
        .sts_excess(sts_excess), .sts_late(sts_late), .sts_ufl(sts_ufl), .sts_ovf(sts_ovf)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int    m_cnt = 0;
    bit    m_retry = 0, m_drop = 0, m_wait = 0;
    bit    m_exc = 0, m_late = 0, m_ufl = 0, m_ovf = 0;
    int    m_mask = 0;
    string m_tag = "R9";
    bit    busy_prev = 0;
    int    run = 0;
    int    cur_mask = 0;
    int    nonzero_waits = 0;

    always @(posedge clk) begin
        m_retry = 0; m_drop = 0; m_wait = 0;
        if (rst) begin
            m_cnt = 0; m_exc = 0; m_late = 0; m_ufl = 0; m_ovf = 0;
        end else begin
            if (clr_status) begin m_exc = 0; m_late = 0; m_ufl = 0; m_ovf = 0; end
            if (ev_valid && !busy_prev) begin
                int  n;
                bit  ex, en;
                n  = m_cnt + 1;
                ex = ev_coll && (n == MAXA);
                if (ex) m_exc = 1;
                if (ev_coll && ev_late) m_late = 1;
                if (ev_ufl) m_ufl = 1;
                if (ev_ovf) m_ovf = 1;
                if (ev_ovf) begin
                    m_drop = 1; m_cnt = 0; m_tag = "R6";
                end else if (ev_coll) begin
                    en = (ev_late || ex) ? en_fatal_retry : en_coll_retry;
                    m_tag = ev_late ? "R3" : (ex ? "R4" : "R1");
                    if (en) begin
                        m_retry = 1; m_wait = 1;
                        m_mask = (1 << ((n < CAP) ? n : CAP)) - 1;
                        m_cnt = ex ? 0 : n;
                    end else begin
                        m_drop = 1; m_cnt = 0;
                    end
                end else if (ev_ufl) begin
                    m_tag = "R5";
                    if (en_ufl_retry) m_retry = 1; else m_drop = 1;
                    m_cnt = 0;
                end else begin
                    m_tag = "R7"; m_cnt = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(retry_pulse == m_retry, m_tag, "retry_pulse", retry_pulse, m_retry);
            chk(drop_pulse == m_drop, m_tag, "drop_pulse", drop_pulse, m_drop);
            chk(!(retry_pulse && drop_pulse), "R9", "retry&drop together", 1, 0);
            chk(sts_excess == m_exc, "R4 R8", "sts_excess", sts_excess, m_exc);
            chk(sts_late == m_late, "R3 R8", "sts_late", sts_late, m_late);
            chk(sts_ufl == m_ufl, "R5 R8", "sts_ufl", sts_ufl, m_ufl);
            chk(sts_ovf == m_ovf, "R6 R8", "sts_ovf", sts_ovf, m_ovf);
            if (m_wait) cur_mask = m_mask;
            if (backoff_busy && !busy_prev)
                chk(m_wait, "R10", "busy rose without collision retry", 1, int'(m_wait));
            if ((m_retry || m_drop) && !m_wait)
                chk(!backoff_busy, "R5 R10", "busy after non-waiting action", backoff_busy, 0);
            if (backoff_busy) run++;
            if (!backoff_busy && busy_prev) begin
                chk((run % SLOT) == 0, "R2", "busy length not whole slots", run, (run / SLOT) * SLOT);
                chk((run / SLOT) <= cur_mask && run > 0, "R2 R7", "slots beyond window", run / SLOT, cur_mask);
                nonzero_waits++;
                run = 0;
            end
        end
        busy_prev = backoff_busy;
    end

    task automatic wait_idle();
        while (backoff_busy) @(negedge clk);
    endtask

    task automatic report(input bit c, input bit l, input bit u, input bit o);
        wait_idle();
        ev_valid = 1; ev_coll = c; ev_late = l; ev_ufl = u; ev_ovf = o;
        @(negedge clk);
        ev_valid = 0; ev_coll = 0; ev_late = 0; ev_ufl = 0; ev_ovf = 0;
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        clr_status = 1;
        @(negedge clk);
        clr_status = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: reset state
        chk({retry_pulse, drop_pulse, backoff_busy, sts_excess, sts_late, sts_ufl, sts_ovf} == 7'b0,
            "R11", "outputs after reset",
            int'({retry_pulse, drop_pulse, backoff_busy, sts_excess, sts_late, sts_ufl, sts_ovf}), 0);

        // R7: success gives nothing
        report(0, 0, 0, 0);

        // R1: ordinary collisions, retry enabled then disabled
        en_coll_retry = 1;
        for (int i = 0; i < 3; i++) report(1, 0, 0, 0);
        en_coll_retry = 0;
        report(1, 0, 0, 0);

        // R4: sixteen in a row, fatal retry disabled, then enabled
        en_coll_retry = 1;
        for (int i = 0; i < MAXA; i++) report(1, 0, 0, 0);
        report(1, 0, 0, 0);       // R7: count restarted, window 1
        wait_idle();
        report(0, 0, 0, 0);
        pulse_clear();
        en_fatal_retry = 1;
        for (int i = 0; i < MAXA; i++) report(1, 0, 0, 0);
        report(1, 0, 0, 0);
        wait_idle();
        report(0, 0, 0, 0);

        // R3: late collisions
        en_fatal_retry = 0;
        report(1, 1, 0, 0);
        en_fatal_retry = 1;
        report(1, 1, 0, 0);
        wait_idle();

        // R5: underflow, and collision precedence
        pulse_clear();
        report(0, 0, 1, 0);
        en_ufl_retry = 1;
        report(0, 0, 1, 0);
        en_coll_retry = 0;
        report(1, 0, 1, 0);

        // R6: overflow with every enable set
        en_coll_retry = 1; en_fatal_retry = 1; en_ufl_retry = 1;
        report(0, 0, 0, 1);
        report(1, 0, 1, 1);

        // R8: clear together with a new error keeps the flag
        wait_idle();
        clr_status = 1; ev_valid = 1; ev_ufl = 1;
        @(negedge clk);
        clr_status = 0; ev_valid = 0; ev_ufl = 0;
        @(negedge clk);
        chk(sts_ufl && !sts_ovf, "R8", "set wins over clear", int'({sts_ufl, sts_ovf}), 2);

        // R10: report during busy is ignored
        pulse_clear();
        en_coll_retry = 1;
        for (int tries = 0; tries < 12 && !backoff_busy; tries++) begin
            ev_valid = 1; ev_coll = 1;
            @(negedge clk);
            ev_valid = 0; ev_coll = 0;
            @(negedge clk);
        end
        chk(backoff_busy, "R10", "backoff never started", backoff_busy, 1);
        if (backoff_busy) begin
            ev_valid = 1; ev_ovf = 1; ev_late = 1; ev_coll = 1;
            @(negedge clk);
            ev_valid = 0; ev_ovf = 0; ev_late = 0; ev_coll = 0;
            @(negedge clk);
            chk(!drop_pulse && !sts_ovf && !sts_late, "R10", "report while busy had effect",
                int'({drop_pulse, sts_ovf, sts_late}), 0);
        end
        wait_idle();
        report(0, 0, 0, 0);

        // mixed outcomes
        for (int i = 0; i < 40; i++) begin
            bit c, l, u, o;
            int r;
            r = $urandom_range(0, 99);
            c = (r < 55); l = c && (r < 10); u = (r >= 50 && r < 80); o = (r >= 95);
            en_coll_retry  = ($urandom_range(0, 3) != 0);
            en_fatal_retry = $urandom_range(0, 1);
            en_ufl_retry   = $urandom_range(0, 1);
            if ($urandom_range(0, 9) == 0) pulse_clear();
            report(c, l, u, o);
        end
        wait_idle();
        @(negedge clk);
        chk(nonzero_waits > 0, "R2", "no non-zero backoff seen", nonzero_waits, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule